// File: doc/BRIEF.md
# PCI Address Translation Window Unit

This block holds the address windows of a PCI host bridge and answers translation lookups against them. Four outbound windows turn CPU addresses into PCI bus addresses, and three inbound windows turn PCI bus addresses into local memory addresses. Each window has four 32-bit registers:

- a translation target page
- an extended word
- a base page
- an attribute word, which holds the enable bit and a size code

All of these are reached through a simple register slave. The slave has an address, a write strobe, write data and combinational read data.

Two lookup ports, one per direction, are purely combinational. An address goes in, and a hit flag and the translated address come out in the same cycle. They carry no valid/ready handshake. They never stall, so there is no back-pressure to manage. A caller that registers the result samples it in the cycle it presents the address. Base and target registers hold page numbers, meaning address bits 12 and up. Lookup addresses are therefore 44 bits wide.

Top module: `pci_xlat_unit`

## Requirements
- R1: After reset every register reads zero, both lookup ports report hit low, and each port's translated output equals its input address.
- R2: Outbound window k (k = 0 to 3) occupies the 32-byte group at 0xC20 + 32·k. Its target page is at +0x00, its extended word at +0x04, its base page at +0x08 and its attributes at +0x10. Each reads back the last value written.
- R3: Inbound window k (k = 0 to 2) occupies the 32-byte group at 0xDA0 + 32·k. Its target page is at +0x00, its base page at +0x08, its extended word at +0x0C and its attributes at +0x10. Each reads back the last value written.
- R4: Any address from 0xE20 to 0xE3F reaches one 32-bit timer word, which is plain read/write storage.
- R5: Every other register address reads zero, and a write to it changes no register. This covers addresses below 0xC00, unused offsets inside a window group, and unaligned offsets.
- R6: An enabled window hits when base·4096 ≤ addr < base·4096 + 2^(S+1). S is attribute bits [5:0]. A window whose size reaches past the top of the 44-bit space covers everything above its base.
- R7: On a hit, the translated address is target·4096 + (addr − base·4096), taken modulo 2^44.
- R8: A window with attribute bit 31 clear never hits. When no window hits, hit is low and the translated output equals the input address.
- R9: When several enabled windows of one direction hit, the one with the lowest index k supplies the translation.
- R10: A register write changes the lookup results from the clock edge that accepts it, and not before.
- R11: The extended words are storage only and have no effect on any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address within the 4 KB block |
| reg_we | input | 1 | Write strobe, accepted at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ob_addr | input | 44 | CPU address for outbound lookup |
| ob_hit | output | 1 | An outbound window matched |
| ob_xlat | output | 44 | Translated PCI address, or ob_addr on a miss |
| ib_addr | input | 44 | PCI address for inbound lookup |
| ib_hit | output | 1 | An inbound window matched |
| ib_xlat | output | 44 | Translated local address, or ib_addr on a miss |

## Verification
The bench builds the unit with its defaults: four outbound windows and three inbound windows. This puts every register group of both directions in reach, including the group above the last outbound window, which must stay dead. Random rounds reprogram all seven windows with small base pages and size codes from 11 to 22. Lookups then land on, just before and just past each window edge, so overlaps between windows arise often and test the lowest-index rule. Directed cases add the largest size code, which saturates the window to the top of the 44-bit space, and a write whose effect is observed on both sides of the accepting edge.

// File: rtl/pci_xlat_pkg.sv
package pci_xlat_pkg;
  localparam int REG_W      = 32;
  localparam int REG_AW     = 12;
  localparam int PAGE_SHIFT = 12;
  localparam int LA_W       = REG_W + PAGE_SHIFT;

  // full register contents of one window
  typedef struct packed {
    logic [REG_W-1:0] tgt;
    logic [REG_W-1:0] ext;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] attr;
  } win_regs_t;

  // the part of a window a lookup needs
  typedef struct packed {
    logic [REG_W-1:0] tgt;
    logic [REG_W-1:0] base;
    logic             en;
    logic [5:0]       size_code;
  } win_map_t;
endpackage

// File: rtl/pci_xlat_regs.sv
module pci_xlat_regs
  import pci_xlat_pkg::*;
#(
  parameter int NUM_OB = 4,  // 1..7
  parameter int NUM_IB = 3   // 1..3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic                     reg_we,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output win_map_t [NUM_OB-1:0]    ob_map,
  output win_map_t [NUM_IB-1:0]    ib_map
);
  win_regs_t [NUM_OB-1:0] ob_q;
  win_regs_t [NUM_IB-1:0] ib_q;
  logic [REG_W-1:0]       tmr_q;

  logic ob_grp, ib_grp, tmr_grp;
  logic [4:0] sub;

  assign ob_grp  = (reg_addr[11:8] == 4'hC);
  assign ib_grp  = (reg_addr[11:7] == 5'b11011);
  assign tmr_grp = (reg_addr[11:5] == 7'h71);
  assign sub     = reg_addr[4:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_q  <= '0;
      ib_q  <= '0;
      tmr_q <= '0;
    end else if (reg_we) begin
      for (int k = 0; k < NUM_OB; k++) begin
        if (ob_grp && reg_addr[7:5] == 3'(k + 1)) begin
          case (sub)
            5'h00: ob_q[k].tgt  <= reg_wdata;
            5'h04: ob_q[k].ext  <= reg_wdata;
            5'h08: ob_q[k].base <= reg_wdata;
            5'h10: ob_q[k].attr <= reg_wdata;
            default: ;
          endcase
        end
      end
      for (int k = 0; k < NUM_IB; k++) begin
        if (ib_grp && reg_addr[6:5] == 2'(k + 1)) begin
          case (sub)
            5'h00: ib_q[k].tgt  <= reg_wdata;
            5'h08: ib_q[k].base <= reg_wdata;
            5'h0C: ib_q[k].ext  <= reg_wdata;
            5'h10: ib_q[k].attr <= reg_wdata;
            default: ;
          endcase
        end
      end
      if (tmr_grp) tmr_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_OB; k++) begin
      if (ob_grp && reg_addr[7:5] == 3'(k + 1)) begin
        case (sub)
          5'h00: reg_rdata = ob_q[k].tgt;
          5'h04: reg_rdata = ob_q[k].ext;
          5'h08: reg_rdata = ob_q[k].base;
          5'h10: reg_rdata = ob_q[k].attr;
          default: ;
        endcase
      end
    end
    for (int k = 0; k < NUM_IB; k++) begin
      if (ib_grp && reg_addr[6:5] == 2'(k + 1)) begin
        case (sub)
          5'h00: reg_rdata = ib_q[k].tgt;
          5'h08: reg_rdata = ib_q[k].base;
          5'h0C: reg_rdata = ib_q[k].ext;
          5'h10: reg_rdata = ib_q[k].attr;
          default: ;
        endcase
      end
    end
    if (tmr_grp) reg_rdata = tmr_q;
  end

  for (genvar k = 0; k < NUM_OB; k++) begin : g_ob_map
    assign ob_map[k] = '{tgt: ob_q[k].tgt, base: ob_q[k].base,
                         en: ob_q[k].attr[31], size_code: ob_q[k].attr[5:0]};
  end
  for (genvar k = 0; k < NUM_IB; k++) begin : g_ib_map
    assign ib_map[k] = '{tgt: ib_q[k].tgt, base: ib_q[k].base,
                         en: ib_q[k].attr[31], size_code: ib_q[k].attr[5:0]};
  end

  AST_LOW_SPACE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[11:10] != 2'b11) |-> (reg_rdata == '0)); // R5

  AST_TIMER_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && tmr_grp) |=> (tmr_q == $past(reg_wdata))); // R4
endmodule

// File: rtl/pci_xlat_match.sv
module pci_xlat_match
  import pci_xlat_pkg::*;
(
  input  win_map_t         win,
  input  logic [LA_W-1:0]  addr,
  output logic             hit,
  output logic [LA_W-1:0]  xlat
);
  logic [LA_W-1:0] base_a;
  logic [LA_W-1:0] diff;
  logic [6:0]      size_log2;
  logic            in_size;

  assign base_a    = {win.base, {PAGE_SHIFT{1'b0}}};
  assign diff      = addr - base_a;
  assign size_log2 = {1'b0, win.size_code} + 7'd1;
  assign in_size   = (size_log2 >= 7'(LA_W)) ? 1'b1 : ((diff >> size_log2) == '0);
  assign hit       = win.en && (addr >= base_a) && in_size;
  assign xlat      = {win.tgt, {PAGE_SHIFT{1'b0}}} + diff;
endmodule

// File: rtl/pci_xlat_lookup.sv
module pci_xlat_lookup
  import pci_xlat_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  win_map_t [NUM_WIN-1:0] wins,
  input  logic [LA_W-1:0]        addr,
  output logic                   hit,
  output logic [LA_W-1:0]        xlat
);
  logic [NUM_WIN-1:0] m_hit;
  logic [NUM_WIN-1:0] m_en;
  logic [LA_W-1:0]    m_xlat [NUM_WIN];

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    pci_xlat_match u_match (
      .win  (wins[k]),
      .addr (addr),
      .hit  (m_hit[k]),
      .xlat (m_xlat[k])
    );
    assign m_en[k] = wins[k].en;
  end

  // scan from the top so the lowest index overrides
  always_comb begin
    hit  = 1'b0;
    xlat = addr;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (m_hit[k]) begin
        hit  = 1'b1;
        xlat = m_xlat[k];
      end
    end
  end

  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (|m_en)); // R8

  AST_WINDOW0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    m_hit[0] |-> (hit && xlat == m_xlat[0])); // R9
endmodule

// File: rtl/pci_xlat_unit.sv
module pci_xlat_unit
  import pci_xlat_pkg::*;
#(
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [43:0]       ob_addr,
  output logic              ob_hit,
  output logic [43:0]       ob_xlat,
  input  logic [43:0]       ib_addr,
  output logic              ib_hit,
  output logic [43:0]       ib_xlat
);
  win_map_t [NUM_OB-1:0] ob_map;
  win_map_t [NUM_IB-1:0] ib_map;

  pci_xlat_regs #(.NUM_OB(NUM_OB), .NUM_IB(NUM_IB)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ob_map    (ob_map),
    .ib_map    (ib_map)
  );

  pci_xlat_lookup #(.NUM_WIN(NUM_OB)) u_ob (
    .clk (clk), .rst_n (rst_n), .wins (ob_map),
    .addr (ob_addr), .hit (ob_hit), .xlat (ob_xlat)
  );

  pci_xlat_lookup #(.NUM_WIN(NUM_IB)) u_ib (
    .clk (clk), .rst_n (rst_n), .wins (ib_map),
    .addr (ib_addr), .hit (ib_hit), .xlat (ib_xlat)
  );

  AST_OB_QUIET_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ob_addr) && !$past(reg_we)) |-> ($stable(ob_hit) && $stable(ob_xlat))); // R10

  AST_IB_QUIET_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ib_addr) && !$past(reg_we)) |-> ($stable(ib_hit) && $stable(ib_xlat))); // R10
endmodule

// File: tb/pci_xlat_unit_tb.sv
module pci_xlat_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [43:0] ob_addr = '0, ib_addr = '0;
  logic        ob_hit, ib_hit;
  logic [43:0] ob_xlat, ib_xlat;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model: field 0 target, 1 extended, 2 base, 3 attributes
  logic [31:0] m_ob [4][4];
  logic [31:0] m_ib [3][4];
  logic [31:0] m_tmr;

  always #10 clk = ~clk;

  pci_xlat_unit u_dut (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_we (reg_we),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .ob_addr (ob_addr), .ob_hit (ob_hit), .ob_xlat (ob_xlat),
    .ib_addr (ib_addr), .ib_hit (ib_hit), .ib_xlat (ib_xlat)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 outbound, 2 inbound, 3 timer
  function automatic void decode(input logic [11:0] a, output int kind, output int idx, output int fld);
    logic [11:0] ob_off [4] = '{12'h00, 12'h04, 12'h08, 12'h10};
    logic [11:0] ib_off [4] = '{12'h00, 12'h0C, 12'h08, 12'h10};
    kind = 0; idx = 0; fld = 0;
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 4; f++)
        if (a == 12'hC20 + 12'(32 * k) + ob_off[f]) begin kind = 1; idx = k; fld = f; end
    for (int k = 0; k < 3; k++)
      for (int f = 0; f < 4; f++)
        if (a == 12'hDA0 + 12'(32 * k) + ib_off[f]) begin kind = 2; idx = k; fld = f; end
    if (a >= 12'hE20 && a <= 12'hE3F) kind = 3;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int kind, idx, fld;
    decode(a, kind, idx, fld);
    case (kind)
      1: return m_ob[idx][fld];
      2: return m_ib[idx][fld];
      3: return m_tmr;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [44:0] exp_look(input bit outb, input logic [43:0] a);
    int n = outb ? 4 : 3;
    for (int k = 0; k < n; k++) begin
      logic [31:0] t = outb ? m_ob[k][0] : m_ib[k][0];
      logic [31:0] b = outb ? m_ob[k][2] : m_ib[k][2];
      logic [31:0] w = outb ? m_ob[k][3] : m_ib[k][3];
      logic [63:0] lo = 64'(b) * 64'd4096;
      int e = int'(w[5:0]) + 1;
      if (w[31] && 64'(a) >= lo && (e >= 44 || 64'(a) - lo < (64'd1 << e)))
        return {1'b1, 44'(64'(t) * 64'd4096 + 64'(a) - lo)};
    end
    return {1'b0, a};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    int kind, idx, fld;
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    decode(a, kind, idx, fld);
    case (kind)
      1: m_ob[idx][fld] = d;
      2: m_ib[idx][fld] = d;
      3: m_tmr = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    reg_addr = a; #1;
    chk(req, 64'(reg_rdata), 64'(exp_rd(a)));
  endtask

  task automatic look_chk(input string req, input logic [43:0] oa, input logic [43:0] ia);
    logic [44:0] eo, ei;
    ob_addr = oa; ib_addr = ia; #1;
    eo = exp_look(1'b1, oa); ei = exp_look(1'b0, ia);
    chk(req, {ob_hit, ob_xlat}, 64'(eo));
    chk(req, {ib_hit, ib_xlat}, 64'(ei));
  endtask

  task automatic sweep_regs(input string req);
    for (int a = 12'hC00; a < 12'hE40; a += 4) rd_chk(req, 12'(a));
  endtask

  function automatic logic [11:0] ob_a(input int k, input logic [11:0] off);
    return 12'hC20 + 12'(32 * k) + off;
  endfunction
  function automatic logic [11:0] ib_a(input int k, input logic [11:0] off);
    return 12'hDA0 + 12'(32 * k) + off;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 4; k++) for (int f = 0; f < 4; f++) m_ob[k][f] = '0;
    for (int k = 0; k < 3; k++) for (int f = 0; f < 4; f++) m_ib[k][f] = '0;
    m_tmr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    sweep_regs("R1 reset readback");
    look_chk("R1 reset lookup", 44'h123_4567_89AB, 44'h0FE_DCBA_9876);

    // R2 R3 R4: fill every register, read back
    for (int k = 0; k < 4; k++) begin
      wr(ob_a(k, 12'h00), $urandom); wr(ob_a(k, 12'h04), $urandom);
      wr(ob_a(k, 12'h08), $urandom); wr(ob_a(k, 12'h10), $urandom & 32'h7FFF_FFFF);
    end
    for (int k = 0; k < 3; k++) begin
      wr(ib_a(k, 12'h00), $urandom); wr(ib_a(k, 12'h08), $urandom);
      wr(ib_a(k, 12'h0C), $urandom); wr(ib_a(k, 12'h10), $urandom & 32'h7FFF_FFFF);
    end
    wr(12'hE3C, 32'hA5A5_0F0F);
    for (int k = 0; k < 4; k++) begin
      rd_chk("R2 ob target", ob_a(k, 12'h00)); rd_chk("R2 ob ext", ob_a(k, 12'h04));
      rd_chk("R2 ob base", ob_a(k, 12'h08)); rd_chk("R2 ob attr", ob_a(k, 12'h10));
    end
    for (int k = 0; k < 3; k++) begin
      rd_chk("R3 ib target", ib_a(k, 12'h00)); rd_chk("R3 ib base", ib_a(k, 12'h08));
      rd_chk("R3 ib ext", ib_a(k, 12'h0C)); rd_chk("R3 ib attr", ib_a(k, 12'h10));
    end
    rd_chk("R4 timer alias", 12'hE20);
    chk("R4 timer value", 64'(reg_rdata), 64'hA5A5_0F0F);

    // R5: writes to dead addresses change nothing
    begin
      logic [11:0] dead [10] = '{12'h000, 12'hBFC, 12'hC00, 12'hC0C, 12'hC2C,
                                 12'hCA0, 12'hD80, 12'hDA4, 12'hDB4, 12'hC21};
      for (int i = 0; i < 10; i++) wr(dead[i], 32'hFFFF_FFFF);
      for (int i = 0; i < 10; i++) begin
        reg_addr = dead[i]; #1;
        chk("R5 dead read", 64'(reg_rdata), 64'h0);
      end
    end
    sweep_regs("R5 map intact");

    // clear all attributes
    for (int k = 0; k < 4; k++) wr(ob_a(k, 12'h10), 32'h0);
    for (int k = 0; k < 3; k++) wr(ib_a(k, 12'h10), 32'h0);
    look_chk("R8 all disabled", 44'h000_0010_0000, 44'h000_0010_0000);

    // R6 R7: outbound 0 base page 0x100, target page 0x5000, size 2^13
    wr(ob_a(0, 12'h08), 32'h100); wr(ob_a(0, 12'h00), 32'h5000);
    // R10: write enable, sample before and after the accepting edge
    @(negedge clk);
    reg_addr = ob_a(0, 12'h10); reg_we = 1'b1; reg_wdata = 32'h8000_000C;
    ob_addr = 44'h10_0000; #1;
    chk("R10 before edge", 64'(ob_hit), 64'h0);
    @(negedge clk);
    reg_we = 1'b0; m_ob[0][3] = 32'h8000_000C;
    chk("R10 after edge", 64'(ob_hit), 64'h1);
    chk("R7 xlat at base", 64'(ob_xlat), 64'h500_0000);
    look_chk("R6 below base", 44'h0F_FFFF, 0);
    look_chk("R6 last byte", 44'h10_1FFF, 0);
    chk("R7 last byte value", 64'(ob_xlat), 64'h500_1FFF);
    look_chk("R6 one past end", 44'h10_2000, 0);
    chk("R6 one past hit", 64'(ob_hit), 64'h0);
    // R11: extended word ignored
    wr(ob_a(0, 12'h04), 32'hDEAD_BEEF);
    look_chk("R11 ext ignored", 44'h10_0123, 0);
    chk("R11 xlat value", 64'(ob_xlat), 64'h500_0123);
    // R9: window 1 overlaps with other target
    wr(ob_a(1, 12'h08), 32'h100); wr(ob_a(1, 12'h00), 32'h7000);
    wr(ob_a(1, 12'h10), 32'h8000_000C);
    look_chk("R9 overlap", 44'h10_0040, 0);
    chk("R9 lowest wins", 64'(ob_xlat), 64'h500_0040);
    wr(ob_a(0, 12'h10), 32'h0000_000C);
    look_chk("R8 disable window0", 44'h10_0040, 0);
    chk("R9 next window", 64'(ob_xlat), 64'h700_0040);
    // R6: largest size code covers the rest of the space
    wr(ib_a(2, 12'h08), 32'h0); wr(ib_a(2, 12'h00), 32'h1);
    wr(ib_a(2, 12'h10), 32'h8000_003F);
    look_chk("R6 saturated low", 0, 44'h000_0000_0000);
    look_chk("R6 saturated top", 0, 44'hFFF_FFFF_FFFF);
    chk("R7 wrap", 64'({ib_hit, ib_xlat}), {19'h0, 1'b1, 44'h000_0000_0FFF});

    // random rounds: R6 R7 R8 R9
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < 4; k++) begin
        wr(ob_a(k, 12'h08), $urandom & 32'hFFFF); wr(ob_a(k, 12'h00), $urandom);
        wr(ob_a(k, 12'h10), {($urandom % 4 != 0), 25'h0, 6'(11 + $urandom % 12)});
      end
      for (int k = 0; k < 3; k++) begin
        wr(ib_a(k, 12'h08), $urandom & 32'hFFFF); wr(ib_a(k, 12'h00), $urandom);
        wr(ib_a(k, 12'h10), {($urandom % 4 != 0), 25'h0, 6'(11 + $urandom % 12)});
      end
      for (int i = 0; i < 20; i++) begin
        int jo = $urandom % 4, ji = $urandom % 3;
        int so = int'(m_ob[jo][3][5:0]) + 1, si = int'(m_ib[ji][3][5:0]) + 1;
        logic [43:0] oa = {m_ob[jo][2], 12'h0} + 44'($urandom % (32'd1 << (so + 1))) - 44'(32'd1 << (so - 1));
        logic [43:0] ia = {m_ib[ji][2], 12'h0} + 44'($urandom % (32'd1 << (si + 1))) - 44'(32'd1 << (si - 1));
        look_chk("R6 R7 R9 random", oa, ia);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule